// File: doc/BRIEF.md
# Vector Element Operation Event Counters

This block is a bank of fifteen 64-bit performance counters that watches a retire interface for vector instructions. In any cycle the interface may report one retired vector instruction. The report carries its class (integer or floating point), its element width, its register grouping factor, its active vector length, a multiply-add flag, an "unmasked" flag and a per-element mask.

Three counters count instructions: all of them, the integer ones and the floating-point ones. Twelve counters count element operations, in pairs. There is a pair for each of integer 8, 16, 32 and 64 bit, single precision and double precision. One counter of each pair adds only the elements that are enabled by the mask. The other adds every element inside the active length and ignores the mask. A multiply-add counts two operations per element.

A read port returns one counter, chosen by a 4-bit index, in the same cycle. A clear strobe zeroes the whole bank. All counters wrap modulo 2^64.

Top module: `vec_evt_ctr`

## Requirements
- R1: After reset is released, every counter (indices 0 to 14) reads zero.
- R2: For each valid retire, counter 0 adds 1. Counter 1 adds 1 when `ret_fp_i`=0 (integer) and counter 2 adds 1 when `ret_fp_i`=1 (floating point).
- R3: The element count n equals min(`ret_vl_i`, (VLEN/SEW)*LMUL), with VLEN=128. The `ret_sew_i` codes 0,1,2,3 mean SEW of 8,16,32,64. The `ret_lmul_i` codes 0,1,2,3 mean LMUL of 1,2,4,8. Elements at or beyond n are never counted.
- R4: The mask-agnostic counter of the selected pair adds n, whatever `ret_mask_i` holds.
- R5: The mask-aware counter of the selected pair adds the number of set bits among `ret_mask_i[n-1:0]`. When `ret_unmasked_i`=1, it adds n instead.
- R6: When `ret_fma_i`=1, both element counters of the selected pair add twice their amount.
- R7: The element counter indices depend on class and SEW code. For integer, SEW codes 0..3 select counters 3/4, 5/6, 7/8 and 9/10. For floating point, SEW code 2 selects 11/12 and SEW code 3 selects 13/14. Floating point with SEW code 0 or 1 updates no element counter. In each pair, the odd index is mask-aware and the even index is mask-agnostic.
- R8: A retire presented in the cycle before a rising clock edge shows at the read port right after that edge and not before it. Counters hold while `ret_valid_i`=0.
- R9: `rd_data_o` shows counter `rd_idx_i` combinationally, and index 15 reads zero.
- R10: `clr_i`=1 zeroes every counter at the next edge. It takes priority over a retire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ret_valid_i | input | 1 | A retired vector instruction is reported this cycle |
| ret_fp_i | input | 1 | 1 = floating point, 0 = integer |
| ret_sew_i | input | 2 | Element width code (8/16/32/64) |
| ret_lmul_i | input | 2 | Grouping code (1/2/4/8) |
| ret_vl_i | input | 8 | Active vector length |
| ret_fma_i | input | 1 | Multiply-add: each element counts twice |
| ret_unmasked_i | input | 1 | Treat all mask bits as ones |
| ret_mask_i | input | 128 | Per-element mask, bit i for element i |
| clr_i | input | 1 | Zero all counters |
| rd_idx_i | input | 4 | Counter select |
| rd_data_o | output | 64 | Selected counter value |

## Verification
The hardest case to reach is a mask whose set bits lie largely beyond the active length. Here the mask-aware amount depends on which bits fall below n, not on the total number of set bits. The stimulus has several parts. A directed alternating mask over the full register checks the half-lane case. A long active length with a short grouping exercises the clamp to the register capacity. Random runs combine a random active length from 0 to 128 with a full 128-bit random mask, so set bits above n occur in nearly every retire. A clear arriving together with a retire is also driven on purpose, to check that the clear wins.

// File: rtl/vec_evt_pkg.sv
package vec_evt_pkg;
  localparam int NUM_CNT   = 15;
  localparam int NUM_PAIR  = 6;
  localparam int PAIR_BASE = 3;

  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;

  // pair k -> counters PAIR_BASE+2k (mask-aware), PAIR_BASE+2k+1 (agnostic)
  function automatic logic pair_hit(int k, logic fp, logic [1:0] sew);
    if (k < 4) return !fp && (sew == 2'(k));
    else if (k == 4) return fp && (sew == SEW_32);
    else return fp && (sew == SEW_64);
  endfunction
endpackage

// File: rtl/vec_evt_popcnt.sv
module vec_evt_popcnt #(
  parameter int W   = 128,
  parameter int C_W = $clog2(W + 1)
) (
  input  logic [W-1:0]   bits_i,
  output logic [C_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + C_W'(bits_i[i]);
  end
endmodule

// File: rtl/vec_evt_amount.sv
module vec_evt_amount #(
  parameter int VLEN  = 128,
  parameter int VL_W  = $clog2(VLEN + 1),
  parameter int AMT_W = VL_W + 1
) (
  input  logic [1:0]       sew_i,
  input  logic [1:0]       lmul_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             unmasked_i,
  input  logic             fma_i,
  input  logic [VLEN-1:0]  mask_i,
  output logic [AMT_W-1:0] agn_o,
  output logic [AMT_W-1:0] awr_o
);
  logic [VL_W-1:0] vlmax, n_act, pop, awr_base;
  logic [VLEN-1:0] lane_en;

  always_comb begin
    vlmax = VL_W'((VLEN >> (3 + int'(sew_i))) << lmul_i);
    n_act = (vl_i < vlmax) ? vl_i : vlmax;
  end

  for (genvar i = 0; i < VLEN; i++) begin : g_lane
    assign lane_en[i] = (VL_W'(i) < n_act);
  end

  vec_evt_popcnt #(.W(VLEN), .C_W(VL_W)) u_pop (
    .bits_i (mask_i & lane_en),
    .cnt_o  (pop)
  );

  assign awr_base = unmasked_i ? n_act : pop;
  assign agn_o    = fma_i ? {n_act, 1'b0} : {1'b0, n_act};
  assign awr_o    = fma_i ? {awr_base, 1'b0} : {1'b0, awr_base};
endmodule

// File: rtl/vec_evt_bank.sv
module vec_evt_bank #(
  parameter int NUM   = 15,
  parameter int CNT_W = 64,
  parameter int AMT_W = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic [NUM-1:0]             inc_en_i,
  input  logic [NUM-1:0][AMT_W-1:0]  inc_amt_i,
  output logic [NUM-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (clr_i)         q <= '0;
      else if (inc_en_i[g])   q <= q + CNT_W'(inc_amt_i[g]);
    end
    assign cnt_o[g] = q;
  end

  p_clr_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_en_i == '0) |=> $stable(cnt_o));
endmodule

// File: rtl/vec_evt_ctr.sv
module vec_evt_ctr
  import vec_evt_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int CNT_W = 64,
  parameter int VL_W  = $clog2(VLEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ret_valid_i,
  input  logic             ret_fp_i,
  input  logic [1:0]       ret_sew_i,
  input  logic [1:0]       ret_lmul_i,
  input  logic [VL_W-1:0]  ret_vl_i,
  input  logic             ret_fma_i,
  input  logic             ret_unmasked_i,
  input  logic [VLEN-1:0]  ret_mask_i,
  input  logic             clr_i,
  input  logic [3:0]       rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int AMT_W = VL_W + 1;

  logic [AMT_W-1:0]                agn_amt, awr_amt;
  logic [NUM_PAIR-1:0]             pair_sel;
  logic [NUM_CNT-1:0]              inc_en;
  logic [NUM_CNT-1:0][AMT_W-1:0]   inc_amt;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt;

  vec_evt_amount #(.VLEN(VLEN), .VL_W(VL_W), .AMT_W(AMT_W)) u_amount (
    .sew_i      (ret_sew_i),
    .lmul_i     (ret_lmul_i),
    .vl_i       (ret_vl_i),
    .unmasked_i (ret_unmasked_i),
    .fma_i      (ret_fma_i),
    .mask_i     (ret_mask_i),
    .agn_o      (agn_amt),
    .awr_o      (awr_amt)
  );

  // instruction counters
  assign inc_en[0]  = ret_valid_i;
  assign inc_en[1]  = ret_valid_i && !ret_fp_i;
  assign inc_en[2]  = ret_valid_i && ret_fp_i;
  assign inc_amt[0] = AMT_W'(1);
  assign inc_amt[1] = AMT_W'(1);
  assign inc_amt[2] = AMT_W'(1);

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    assign pair_sel[k]                = ret_valid_i && pair_hit(k, ret_fp_i, ret_sew_i);
    assign inc_en[PAIR_BASE + 2*k]    = pair_sel[k];
    assign inc_en[PAIR_BASE + 2*k + 1] = pair_sel[k];
    assign inc_amt[PAIR_BASE + 2*k]    = awr_amt;
    assign inc_amt[PAIR_BASE + 2*k + 1] = agn_amt;
  end

  vec_evt_bank #(.NUM(NUM_CNT), .CNT_W(CNT_W), .AMT_W(AMT_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .inc_en_i  (inc_en),
    .inc_amt_i (inc_amt),
    .cnt_o     (cnt)
  );

  assign rd_data_o = (int'(rd_idx_i) < NUM_CNT) ? cnt[rd_idx_i] : '0;

  p_instr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !clr_i) |=> (cnt[0] == $past(cnt[0]) + 1'b1));

  p_aware_le_agn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |-> (awr_amt <= agn_amt));

  p_fma_even_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_fma_i) |-> (agn_amt[0] == 1'b0 && awr_amt[0] == 1'b0));

  p_one_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pair_sel));

  p_fp_narrow_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_fp_i && !ret_sew_i[1]) |-> (pair_sel == '0));

  p_vl_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !ret_fma_i) |-> (agn_amt <= AMT_W'(ret_vl_i)));
endmodule

// File: tb/vec_evt_ctr_bench.sv
module vec_evt_ctr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 128;
  localparam int VL_W = $clog2(VLEN + 1);
  localparam int NUM  = 15;

  logic clk = 0, rst_ni = 0;
  logic ret_valid = 0, ret_fp = 0, ret_fma = 0, ret_unm = 0, clr = 0;
  logic [1:0] ret_sew = 0, ret_lmul = 0;
  logic [VL_W-1:0] ret_vl = 0;
  logic [VLEN-1:0] ret_mask = '0;
  logic [3:0] rd_idx = 0;
  logic [63:0] rd_data;

  logic [63:0] exp_q [NUM];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_evt_ctr u_vec_evt_ctr (
    .clk_i(clk), .rst_ni(rst_ni), .ret_valid_i(ret_valid), .ret_fp_i(ret_fp),
    .ret_sew_i(ret_sew), .ret_lmul_i(ret_lmul), .ret_vl_i(ret_vl),
    .ret_fma_i(ret_fma), .ret_unmasked_i(ret_unm), .ret_mask_i(ret_mask),
    .clr_i(clr), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic int elem_n(int sew, int lmul, int vl);
    int vmax = (VLEN >> (3 + sew)) << lmul;
    return (vl < vmax) ? vl : vmax;
  endfunction

  function automatic int pop_n(logic [VLEN-1:0] m, int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic model_apply(bit fp, int sew, int lmul, int vl, bit fma, bit unm,
                             logic [VLEN-1:0] m);
    int n = elem_n(sew, lmul, vl);
    int aw = unm ? n : pop_n(m, n);
    int mul = fma ? 2 : 1;
    int base = -1;
    exp_q[0] += 1;
    if (fp) exp_q[2] += 1; else exp_q[1] += 1;
    if (!fp) base = 3 + 2*sew;
    else if (sew == 2) base = 11;
    else if (sew == 3) base = 13;
    if (base >= 0) begin
      exp_q[base]   += 64'(aw * mul);
      exp_q[base+1] += 64'(n * mul);
    end
  endtask

  task automatic drive_ret(bit fp, int sew, int lmul, int vl, bit fma, bit unm,
                           logic [VLEN-1:0] m);
    @(negedge clk);
    clr = 0; ret_valid = 1; ret_fp = fp; ret_sew = 2'(sew); ret_lmul = 2'(lmul);
    ret_vl = VL_W'(vl); ret_fma = fma; ret_unm = unm; ret_mask = m;
    model_apply(fp, sew, lmul, vl, fma, unm, m);
  endtask

  task automatic go_idle();
    @(negedge clk);
    ret_valid = 0; clr = 0;
    @(negedge clk);
  endtask

  task automatic check_one(int idx, logic [63:0] expv, string tag);
    rd_idx = 4'(idx);
    #1;
    n_chk++;
    if (rd_data !== expv) begin
      n_bad++;
      $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, rd_data, expv);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NUM; i++) check_one(i, exp_q[i], tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] old0;
    void'($urandom(32'd4242));
    for (int i = 0; i < NUM; i++) exp_q[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_all("R1 reset");

    // 16 byte elements, alternating mask -> aware 8, agnostic 16
    drive_ret(0, 0, 0, 128, 0, 0, {(VLEN/2){2'b01}});
    go_idle();
    check_one(3, 64'd8, "R5 half mask");
    check_one(4, 64'd16, "R4 full count");
    check_all("R2 R3 sew8");

    drive_ret(0, 1, 0, 128, 0, 1, '0);
    drive_ret(0, 2, 0, 128, 0, 1, '1);
    drive_ret(0, 3, 0, 128, 0, 0, '0);
    go_idle();
    check_one(5, 64'd8, "R5 unmasked flag");
    check_one(8, 64'd4, "R3 sew32");
    check_one(9, 64'd0, "R5 zero mask");
    check_one(10, 64'd2, "R4 sew64");
    check_all("R2 R3 widths");

    drive_ret(1, 2, 1, 5, 1, 0, '1);
    go_idle();
    check_one(11, 64'd10, "R6 fma aware");
    check_one(12, 64'd10, "R6 fma agnostic");
    check_all("R6 R7 single");

    drive_ret(1, 3, 2, 7, 0, 0, {{(VLEN-4){1'b1}}, 4'b0101});
    drive_ret(1, 0, 3, 128, 1, 1, '1);
    drive_ret(1, 1, 0, 9, 0, 1, '1);
    go_idle();
    check_one(13, 64'd5, "R7 double aware");
    check_one(2, 64'd4, "R2 fp instr");
    check_all("R7 narrow fp");

    drive_ret(0, 3, 3, 100, 0, 1, '1);
    drive_ret(0, 0, 3, 200 % 256, 0, 0, {{(VLEN-8){1'b0}}, 8'hff});
    go_idle();
    check_all("R3 clamp");

    // cycle of visibility
    old0 = exp_q[0];
    drive_ret(0, 0, 1, 3, 0, 0, '1);
    check_one(0, old0, "R8 before edge");
    @(negedge clk);
    ret_valid = 0;
    check_one(0, old0 + 1, "R8 after edge");
    repeat (5) @(negedge clk);
    check_all("R8 hold");
    check_one(15, 64'd0, "R9 idx15");

    @(negedge clk);
    clr = 1; ret_valid = 1; ret_fp = 0; ret_sew = 0; ret_lmul = 0; ret_vl = 8'd16;
    ret_mask = '1;
    for (int i = 0; i < NUM; i++) exp_q[i] = '0;
    go_idle();
    check_all("R10 clear wins");

    for (int b = 0; b < 20; b++) begin
      for (int j = 0; j < 20; j++) begin
        logic [VLEN-1:0] m = {$urandom, $urandom, $urandom, $urandom};
        drive_ret(bit'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                  int'($urandom % (VLEN + 1)), bit'($urandom % 2),
                  ($urandom % 4) == 0, m);
        if ($urandom % 5 == 0) begin
          @(negedge clk);
          ret_valid = 0;
        end
      end
      go_idle();
      check_all("R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule